// File: doc/BRIEF.md
# Dual-Bank Mux-Loaded Serial Shifter

This block is a parallel-in, serial-out shift register for video pixel streams. Its parallel load path passes through a two-way selector that picks either a direct word bank (bank A) or a second word bank (bank B). Bank B sits behind a level-sensitive transparent holding latch, so one word can be parked in the latch while the other bank is loaded and shifted out. This is called interleaved loading.

The serial output is the last register stage, so a loaded word leaves most-significant bit first. Chaining one instance's serial output into the next instance's serial input builds longer shifters. A synchronous reset clears the register and leaves the holding latch alone. It exists for test use.

Top module: `dual_bank_shifter`

## Requirements
- R1: The register changes only on a rising edge of `clk`, and `ser_out` always shows stage W-1 of the register (W defaults to 8).
- R2: When `shift_en` is low at a rising edge, all W stages load in parallel from the selector output.
- R3: When `shift_en` is high at a rising edge, stage 0 takes `ser_in`, and each stage n above 0 takes the previous value of stage n-1.
- R4: `sel_b` low selects `a_data` for the parallel load, and `sel_b` high selects the bank-B path.
- R5: While `latch_en` is low, the holding latch keeps its word. A bank-B load then uses that stored word, and any change on `b_data` has no effect on it.
- R6: When `sel_b` and `latch_en` are both high at a load edge, the live `b_data` value passes through the latch into the register.
- R7: The holding latch captures `b_data` whenever `latch_en` is high, whatever the values of `shift_en` and of the register, including while a word is being shifted out.
- R8: A loaded word appears on `ser_out` with bit W-1 first, then bit W-2, and so on down to bit 0 over successive shift edges.
- R9: When two instances are chained (the first one's `ser_out` drives the second one's `ser_in`), they act as one shifter of 2W stages.
- R10: `rst` high at a rising edge clears every register stage to zero and does not change the contents of the holding latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the register updates on the rising edge |
| rst | input | 1 | Synchronous active-high register clear, for test use |
| shift_en | input | 1 | High: shift; low: parallel load |
| sel_b | input | 1 | Load source select: low = bank A, high = bank B path |
| latch_en | input | 1 | Bank-B latch: transparent when high, holds when low |
| a_data | input | W | Bank A parallel word |
| b_data | input | W | Bank B parallel word, fed to the holding latch |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Serial data from stage W-1 |

## Verification
The latch checks assume that `latch_en` changes at most once between two rising clock edges. Under that assumption, a low level seen at two consecutive edges means the latch stayed closed for the whole interval. The assumption also requires that `b_data` does not change in the same instant that `latch_en` falls. The stimulus meets both conditions: every input changes once, one nanosecond after a rising edge, and the sequence changes `b_data` and lowers `latch_en` in separate cycles. The bench reference model tracks the latch contents from the input levels it drives. It compares both chained instances on every falling edge.

// File: rtl/dual_bank_shifter.sv
module dual_bank_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         sel_b,
  input  logic         latch_en,
  input  logic [W-1:0] a_data,
  input  logic [W-1:0] b_data,
  input  logic         ser_in,
  output logic         ser_out
);

  logic [W-1:0] b_hold;
  logic [W-1:0] stages;
  logic [W-1:0] load_word;

  always_latch begin
    if (latch_en) b_hold <= b_data;
  end

  assign load_word = sel_b ? b_hold : a_data;

  always_ff @(posedge clk) begin
    if (rst)           stages <= '0;
    else if (shift_en) stages <= {stages[W-2:0], ser_in};
    else               stages <= load_word;
  end

  assign ser_out = stages[W-1];

endmodule

module shifter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_en,
  input logic         sel_b,
  input logic         latch_en,
  input logic [W-1:0] a_data,
  input logic [W-1:0] b_data,
  input logic         ser_in,
  input logic         ser_out,
  input logic [W-1:0] stages,
  input logic [W-1:0] b_hold
);

  // R10
  clear_on_rst_chk: assert property (@(posedge clk) rst |=> stages == '0);

  // R3
  shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> stages[0] == $past(ser_in));

  // R3
  shift_move_chk: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> stages[W-1] == $past(stages[W-2]));

  // R4
  load_a_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !sel_b) |=> stages == $past(a_data));

  // R6
  load_b_live_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && sel_b && latch_en) |=> stages == $past(b_data));

  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!latch_en && $past(!latch_en)) |-> $stable(b_hold));

  // R1
  out_stage_chk: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !sel_b) |=> ser_out == $past(a_data[W-1]));

endmodule

bind dual_bank_shifter shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .shift_en(shift_en), .sel_b(sel_b),
  .latch_en(latch_en), .a_data(a_data), .b_data(b_data),
  .ser_in(ser_in), .ser_out(ser_out), .stages(stages), .b_hold(b_hold)
);

// File: tb/sim_dual_bank_shifter.sv
`timescale 1ns/1ps
module sim_dual_bank_shifter;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0, sel_b = 1'b0, latch_en = 1'b1, ser_in = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic out0, out1;

  int vectors = 0, miscompares = 0;
  string tag = "R10";
  bit done = 0;

  logic [W-1:0] m0, m1, m_latch;
  logic [W-1:0] shifted_word;

  always #2.5 clk = ~clk;

  dual_bank_shifter #(.W(W)) u0 (
    .clk(clk), .rst(rst), .shift_en(shift_en), .sel_b(sel_b),
    .latch_en(latch_en), .a_data(a_data), .b_data(b_data),
    .ser_in(ser_in), .ser_out(out0)
  );

  dual_bank_shifter #(.W(W)) u1 (
    .clk(clk), .rst(rst), .shift_en(shift_en), .sel_b(sel_b),
    .latch_en(latch_en), .a_data(a_data), .b_data(b_data),
    .ser_in(out0), .ser_out(out1)
  );

  // Behavioural reference: two words in series, latch tracked from driven levels
  always @(posedge clk) begin
    if (rst) begin
      m0 <= '0; m1 <= '0;
    end else if (shift_en) begin
      m0 <= (m0 << 1) | W'(ser_in);
      m1 <= (m1 << 1) | W'(m0[W-1]);
    end else begin
      m0 <= sel_b ? m_latch : a_data;
      m1 <= sel_b ? m_latch : a_data;
    end
  end

  task automatic check(input string t, input logic act, input logic exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done && m0 !== 'x) begin
      check({tag, " first"}, out0, m0[W-1]);
      check({tag, " chained"}, out1, m1[W-1]);
    end
  end

  task automatic drive(input logic se, input logic sb, input logic le,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic si);
    @(posedge clk); #1;
    shift_en = se; sel_b = sb; latch_en = le; a_data = a; b_data = b; ser_in = si;
    if (le) m_latch = b;
  endtask

  initial begin
    m_latch = '0;
    m0 = 'x; m1 = 'x;
    // R10: reset clears; latch loaded during reset survives it
    drive(0, 0, 1, 8'h00, 8'h3C, 0);
    drive(0, 0, 0, 8'h00, 8'h3C, 0);
    drive(0, 0, 0, 8'h00, 8'h3C, 0);
    @(posedge clk); #1; rst = 0;
    tag = "R10";
    drive(0, 1, 0, 8'h00, 8'hF0, 0);
    drive(1, 0, 0, 8'h00, 8'hF0, 1);
    // R2 / R4: load bank A
    tag = "R4";
    drive(0, 0, 0, 8'hA5, 8'hF0, 0);
    // R8 / R7: shift A out MSB first, latch new B word meanwhile
    tag = "R8";
    shifted_word = '0;
    for (int i = 0; i < W; i++) begin
      drive(1, 0, (i == 2), 8'h00, (i >= 2) ? 8'h5A : 8'hF0, i[0]);
      @(negedge clk);
      shifted_word = {shifted_word[W-2:0], out0};
    end
    vectors++;
    if (shifted_word !== 8'hA5) begin
      miscompares++;
      $display("FAIL R8: actual %h expected %h", shifted_word, 8'hA5);
    end
    // R5: B load from closed latch ignores later b_data
    tag = "R5";
    drive(1, 0, 0, 8'h00, 8'hFF, 0);
    drive(0, 1, 0, 8'h00, 8'h0F, 0);
    shifted_word = '0;
    for (int i = 0; i < W; i++) begin
      drive(1, 1, 0, 8'h00, 8'(i * 37), 0);
      @(negedge clk);
      shifted_word = {shifted_word[W-2:0], out0};
    end
    vectors++;
    if (shifted_word !== 8'h5A) begin
      miscompares++;
      $display("FAIL R5: actual %h expected %h", shifted_word, 8'h5A);
    end
    // R6: transparent B load
    tag = "R6";
    drive(0, 1, 1, 8'h00, 8'hC3, 0);
    for (int i = 0; i < W; i++) drive(1, 0, 1, 8'h00, 8'hC3, 1);
    // R7: latch follows b_data while shifting; R2 A load again
    tag = "R7";
    for (int i = 0; i < 4; i++) drive(1, 0, 1, 8'h00, 8'(8'h11 * i), i[1]);
    drive(1, 0, 0, 8'h00, 8'h33, 0);
    drive(0, 1, 0, 8'h00, 8'h99, 0);
    tag = "R2";
    drive(0, 0, 0, 8'h96, 8'h99, 0);
    // R3 / R9: long serial stream through both chained stages
    tag = "R9";
    for (int i = 0; i < 3 * W; i++) drive(1, 0, 0, 8'h00, 8'h99, ((i * 7) % 5) > 1);
    tag = "R3";
    for (int i = 0; i < W; i++) drive(1, 1, 0, 8'hFF, 8'h99, i[0]);
    // R1: inputs change between edges only; register follows edges
    tag = "R1";
    for (int i = 0; i < 6; i++) drive(i[0], i[1], 0, 8'(i * 29), 8'h99, 1);
    // R10: reset mid-stream
    tag = "R10";
    @(posedge clk); #1; rst = 1;
    @(posedge clk); #1; rst = 0;
    drive(0, 1, 0, 8'h00, 8'h77, 0);
    drive(1, 0, 0, 8'h00, 8'h77, 0);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #100000;
    miscompares++;
    done = 1;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule